// File: doc/BRIEF.md
# Line Ones-Density Monitor and Enforcer

This block watches a serial line stream, one bit per strobe, and checks it against two ones-density rules. A run of more than fifteen zeros breaks the first rule. The second rule is a family of sliding windows: for every N from 1 to 23, any stretch of 8×(N+1) consecutive bits must hold at least N ones. Every accepted bit is checked against all 23 windows and the zero-run limit together. A bit that completes a breach raises a one-cycle violation pulse, which a latched status register can capture. The block also pulses a flag when a bit ends a run of at least eight zeros and another when it ends a run of at least sixteen.

Two instances are used, one on the transmit path and one on the receive path, and each has its own violation flag. On the transmit instance the enforce input can be raised. When it is high, a zero that would complete a breach goes out as a one, and the history records that forced one. The stream that leaves the block then stays within both rules whatever data arrives. Enforcement is meant to stay off when the line code already guarantees density, for example B8ZS. On the receive instance enforcement is tied low, so the block only monitors.

All checks act on the output stream, the bits after any forcing. After reset, the history counts as all ones, so the bits that follow reset are judged only against each other.

Top module: `pdm_density_guard`

## Requirements
- R1: After reset, bit_out, dens_viol, zero8_det and zero16_det are all 0.
- R2: With enf_en low, each bit sampled while bit_vld is high appears unchanged on bit_out in the clock cycle after the strobe.
- R3: With enf_en low, the output bit that is the sixteenth consecutive zero, or any later zero of the same run, raises dens_viol in the cycle after its strobe.
- R4: For each N from 1 to 23, dens_viol rises in the cycle after a strobe when the 8×(N+1) output bits ending with the current bit hold fewer than N ones. Bits from before reset count as ones.
- R5: With enf_en high, an input 0 is sent as 1 when sending it as 0 would break R3 or R4, and an input 1 is always sent as 1. If enf_en has been high for every bit since reset, dens_viol never rises.
- R6: zero8_det pulses in the cycle after a strobe whose output bit is 0 and ends a run of at least 8 consecutive output zeros.
- R7: zero16_det pulses in the cycle after a strobe whose output bit is 0 and ends a run of at least 16 consecutive output zeros.
- R8: In any cycle that does not follow a strobe, dens_viol, zero8_det and zero16_det are 0, and bit_out keeps its previous value.
- R9: The window counts and zero runs use the bit actually sent, so a forced one counts as a one in all later checks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_vld | input | 1 | Strobe: bit_in is taken in this cycle |
| bit_in | input | 1 | Serial data bit |
| enf_en | input | 1 | Enables forcing of ones on the output |
| bit_out | output | 1 | Output bit, after any forcing |
| dens_viol | output | 1 | One-cycle pulse: the last bit broke a density rule |
| zero8_det | output | 1 | One-cycle pulse: the last bit ends a run of 8 or more zeros |
| zero16_det | output | 1 | One-cycle pulse: the last bit ends a run of 16 or more zeros |

## Verification
Every result of a strobe is registered once. bit_out and all three flags are due in the one clock cycle that follows the strobe edge, and the flags drop back to 0 one cycle later unless another strobe arrives. The bench drives each bit on a falling edge. It compares all four outputs on the next falling edge against a model that rescans its own 192-bit copy of the sent stream. In the idle cycles it places between bits, it checks that the flags are low and bit_out has not moved.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

   // number of bits the history must hold so that the longest window
   // (blk*(nmax+1) bits including the current one) can be evaluated
   function automatic int hist_bits(input int blk, input int nmax);
      return blk * (nmax + 1) - 1;
   endfunction

   // bits needed to hold a count from 0 to v
   function automatic int cnt_width(input int v);
      return $clog2(v + 1);
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pdm_history.sv
module pdm_history #(
   parameter int BLK  = 8,
   parameter int NMAX = 23,
   parameter int CW   = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     shift_en,
   input  logic                     new_bit,
   output logic [NMAX-1:0][CW-1:0]  cnt_o
);
   import pdm_pkg::*;

   localparam int HIST = hist_bits(BLK, NMAX);

   if (BLK < 2) begin : g_bad_blk
      $error("pdm_history: BLK must be at least 2");
   end
   if (NMAX < 1) begin : g_bad_nmax
      $error("pdm_history: NMAX must be at least 1");
   end
   if (CW < cnt_width(HIST)) begin : g_bad_cw
      $error("pdm_history: CW too narrow for the longest window");
   end

   // index 0 is the most recent sent bit
   logic [HIST-1:0] hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q <= '1;
      else if (shift_en) hist_q <= {hist_q[HIST-2:0], new_bit};
   end

   // one running ones-count per window: holds the ones among the
   // PRIOR most recent sent bits (window length minus the current bit)
   for (genvar n = 0; n < NMAX; n++) begin : g_win
      localparam int PRIOR = BLK * (n + 2) - 1;
      logic [CW-1:0] c_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) c_q <= CW'(PRIOR);
         else if (shift_en) c_q <= c_q + CW'(new_bit) - CW'(hist_q[PRIOR-1]);
      end

      assign cnt_o[n] = c_q;

      // R4: a window count can never exceed the bits it spans
      a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
         c_q <= CW'(PRIOR));
   end

endmodule

// File: rtl/pdm_zero_run.sv
module pdm_zero_run #(
   parameter int ZSAT = 15,
   parameter int ZW   = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          shift_en,
   input  logic          new_bit,
   output logic [ZW-1:0] run_o
);
   import pdm_pkg::*;

   if (ZW < cnt_width(ZSAT)) begin : g_bad_zw
      $error("pdm_zero_run: ZW too narrow for ZSAT");
   end

   logic [ZW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= '0;
      else if (shift_en) begin
         if (new_bit) run_q <= '0;
         else if (run_q != ZW'(ZSAT)) run_q <= run_q + 1'b1;
      end
   end

   assign run_o = run_q;

   // R3: the saturating run counter stays within its range
   a_r3_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= ZW'(ZSAT));

   // R3: a sent one ends the run
   a_r3_run_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en && new_bit |=> run_q == '0);

endmodule

// File: rtl/pdm_decide.sv
module pdm_decide #(
   parameter int NMAX   = 23,
   parameter int CW     = 8,
   parameter int ZW     = 4,
   parameter int ZLIM   = 15,
   parameter int DSHORT = 8,
   parameter int DLONG  = 16
) (
   input  logic [NMAX-1:0][CW-1:0] cnt_i,
   input  logic [ZW-1:0]           run_i,
   input  logic                    bit_in,
   input  logic                    enf_en,
   output logic                    out_bit,
   output logic                    viol,
   output logic                    z_short,
   output logic                    z_long
);

   if (DSHORT < 1 || DLONG <= DSHORT) begin : g_bad_det
      $error("pdm_decide: need 1 <= DSHORT < DLONG");
   end

   // deficit if the current bit were zero / one, per window
   logic [NMAX-1:0] def_zero;
   logic [NMAX-1:0] def_one;

   for (genvar n = 0; n < NMAX; n++) begin : g_def
      assign def_zero[n] = {1'b0, cnt_i[n]} < (CW+1)'(n + 1);
      assign def_one[n]  = ({1'b0, cnt_i[n]} + (CW+1)'(1)) < (CW+1)'(n + 1);
   end

   logic run_bad;
   logic bad_if_zero;
   logic force_one;

   assign run_bad     = run_i >= ZW'(ZLIM);
   assign bad_if_zero = (|def_zero) | run_bad;
   assign force_one   = enf_en & ~bit_in & bad_if_zero;
   assign out_bit     = bit_in | force_one;
   assign viol        = out_bit ? (|def_one) : bad_if_zero;
   assign z_short     = ~out_bit & (run_i >= ZW'(DSHORT - 1));
   assign z_long      = ~out_bit & (run_i >= ZW'(DLONG - 1));

endmodule

// File: rtl/pdm_density_guard.sv
module pdm_density_guard #(
   parameter int BLK_BITS   = 8,
   parameter int N_MAX      = 23,
   parameter int ZRUN_LIMIT = 15,
   parameter int DET_SHORT  = 8,
   parameter int DET_LONG   = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_vld,
   input  logic bit_in,
   input  logic enf_en,
   output logic bit_out,
   output logic dens_viol,
   output logic zero8_det,
   output logic zero16_det
);
   import pdm_pkg::*;

   localparam int HIST = hist_bits(BLK_BITS, N_MAX);
   localparam int CW   = cnt_width(HIST);
   localparam int ZSAT = imax(ZRUN_LIMIT, DET_LONG - 1);
   localparam int ZW   = cnt_width(ZSAT);

   if (ZRUN_LIMIT < 1) begin : g_bad_lim
      $error("pdm_density_guard: ZRUN_LIMIT must be at least 1");
   end

   logic [N_MAX-1:0][CW-1:0] win_cnt;
   logic [ZW-1:0]            zrun;
   logic                     d_out, d_viol, d_zs, d_zl;

   pdm_history #(.BLK(BLK_BITS), .NMAX(N_MAX), .CW(CW)) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (bit_vld),
      .new_bit  (d_out),
      .cnt_o    (win_cnt)
   );

   pdm_zero_run #(.ZSAT(ZSAT), .ZW(ZW)) u_zrun (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (bit_vld),
      .new_bit  (d_out),
      .run_o    (zrun)
   );

   pdm_decide #(
      .NMAX(N_MAX), .CW(CW), .ZW(ZW), .ZLIM(ZRUN_LIMIT),
      .DSHORT(DET_SHORT), .DLONG(DET_LONG)
   ) u_dec (
      .cnt_i   (win_cnt),
      .run_i   (zrun),
      .bit_in  (bit_in),
      .enf_en  (enf_en),
      .out_bit (d_out),
      .viol    (d_viol),
      .z_short (d_zs),
      .z_long  (d_zl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_out    <= 1'b0;
         dens_viol  <= 1'b0;
         zero8_det  <= 1'b0;
         zero16_det <= 1'b0;
      end else begin
         if (bit_vld) bit_out <= d_out;
         dens_viol  <= bit_vld & d_viol;
         zero8_det  <= bit_vld & d_zs;
         zero16_det <= bit_vld & d_zl;
      end
   end

   // assertion support: enforcement held and no breach since reset
   logic clean_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clean_q <= 1'b1;
      else if (bit_vld && (!enf_en || d_viol)) clean_q <= 1'b0;
   end

   // R2: monitoring only passes data through
   a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
      bit_vld && !enf_en |=> bit_out == $past(bit_in));

   // R5: an input one is never altered
   a_r5_one_kept: assert property (@(posedge clk) disable iff (!rst_n)
      bit_vld && bit_in |=> bit_out);

   // R5: enforcement held since reset leaves no breach
   a_r5_enforced_clean: assert property (@(posedge clk) disable iff (!rst_n)
      clean_q && enf_en && bit_vld |=> !dens_viol);

   // R6: the short zero flag only accompanies a zero bit
   a_r6_short_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
      zero8_det |-> !bit_out);

   // R7: a long zero run is also a short one
   a_r7_long_implies_short: assert property (@(posedge clk) disable iff (!rst_n)
      zero16_det |-> zero8_det);

   // R8: no flag without a strobe, output held
   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_vld |=> !dens_viol && !zero8_det && !zero16_det);

   a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_vld |=> $stable(bit_out));

endmodule

// File: tb/pdm_density_guard_bench.sv
`timescale 1ns/1ps
module pdm_density_guard_bench;

   localparam int HLEN = 192;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_vld = 1'b0;
   logic bit_in = 1'b0;
   logic enf_en = 1'b0;
   logic bit_out, dens_viol, zero8_det, zero16_det;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // model state: sent bits, index 0 newest
   bit ref_h [HLEN];
   bit exp_out, exp_viol, exp_z8, exp_z16;
   bit last_out;
   bit clean;

   always #2 clk = ~clk;

   pdm_density_guard u_pdm_density_guard (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_vld    (bit_vld),
      .bit_in     (bit_in),
      .enf_en     (enf_en),
      .bit_out    (bit_out),
      .dens_viol  (dens_viol),
      .zero8_det  (zero8_det),
      .zero16_det (zero16_det)
   );

   task automatic chk(input string tag, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
      end
   endtask

   task automatic model_init();
      for (int i = 0; i < HLEN; i++) ref_h[i] = 1'b1;
      last_out = 1'b0;
      clean = 1'b1;
   endtask

   // computes the expected results for one bit by rescanning the history
   task automatic model_step(input bit b, input bit en);
      bit def0, def1, bad0;
      int zr, ones, len;
      def0 = 1'b0;
      def1 = 1'b0;
      for (int nn = 1; nn <= 23; nn++) begin
         len = 8 * (nn + 1);
         ones = 0;
         for (int i = 0; i < len - 1; i++) ones += int'(ref_h[i]);
         if (ones < nn) def0 = 1'b1;
         if (ones + 1 < nn) def1 = 1'b1;
      end
      zr = 0;
      for (int i = 0; i < 16; i++) begin
         if (ref_h[i]) break;
         zr++;
      end
      bad0 = def0 || (zr >= 15);
      exp_out  = b | (en & bad0);
      exp_viol = exp_out ? def1 : bad0;
      exp_z8   = !exp_out && (zr >= 7);
      exp_z16  = !exp_out && (zr >= 15);
      for (int i = HLEN - 1; i > 0; i--) ref_h[i] = ref_h[i-1];
      ref_h[0] = exp_out;
      if (!en || exp_viol) clean = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      bit_vld = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model_init();
      @(negedge clk);
      chk("R1", "bit_out after reset", bit_out, 1'b0);
      chk("R1", "dens_viol after reset", dens_viol, 1'b0);
      chk("R1", "zero8_det after reset", zero8_det, 1'b0);
      chk("R1", "zero16_det after reset", zero16_det, 1'b0);
   endtask

   task automatic send(input bit b, input bit en, input string otag, input string vtag);
      @(negedge clk);
      bit_vld = 1'b1;
      bit_in = b;
      enf_en = en;
      model_step(b, en);
      @(negedge clk);
      bit_vld = 1'b0;
      chk(otag, "bit_out", bit_out, exp_out);
      chk(vtag, "dens_viol", dens_viol, exp_viol);
      chk("R6", "zero8_det", zero8_det, exp_z8);
      chk("R7", "zero16_det", zero16_det, exp_z16);
      if (en && clean) chk("R5", "dens_viol while enforced since reset", dens_viol, 1'b0);
      last_out = exp_out;
   endtask

   task automatic idle(input int k);
      for (int i = 0; i < k; i++) begin
         @(negedge clk);
         chk("R8", "dens_viol idle", dens_viol, 1'b0);
         chk("R8", "zero8_det idle", zero8_det, 1'b0);
         chk("R8", "zero16_det idle", zero16_det, 1'b0);
         chk("R8", "bit_out hold", bit_out, last_out);
      end
   endtask

   function automatic bit sparse(input int one_in);
      return ($urandom % one_in) == 0;
   endfunction

   initial begin
      void'($urandom(32'h5eed_1357));
      model_init();
      do_reset();

      // R2: plain pass through
      send(1'b1, 1'b0, "R2", "R4");
      send(1'b0, 1'b0, "R2", "R4");
      idle(2);
      send(1'b1, 1'b0, "R2", "R4");
      send(1'b1, 1'b0, "R2", "R4");
      idle(1);

      // R3, R6, R7: long zero run, unforced
      do_reset();
      for (int i = 0; i < 20; i++) send(1'b0, 1'b0, "R2", "R3");
      send(1'b1, 1'b0, "R2", "R3");
      idle(1);

      // R4: one one per fifteen bits drains the longer windows
      do_reset();
      for (int i = 0; i < 420; i++) send((i % 15) == 0, 1'b0, "R2", "R4");

      // R2, R4: random sparse data, monitor only
      do_reset();
      for (int i = 0; i < 700; i++) begin
         send(sparse(9), 1'b0, "R2", "R4");
         if ((i % 7) == 0) idle($urandom % 3);
      end

      // R5, R9: enforcement from reset, all zeros then sparse random
      do_reset();
      for (int i = 0; i < 250; i++) send(1'b0, 1'b1, "R9", "R5");
      for (int i = 0; i < 700; i++) begin
         send(sparse(13), 1'b1, "R5", "R5");
         if ((i % 11) == 0) idle(1 + ($urandom % 2));
      end

      // R5, R9: enforcement switched on and off over a dirty history
      for (int i = 0; i < 400; i++) begin
         bit en;
         en = ((i / 50) % 2) == 1;
         send(sparse(20), en, en ? "R9" : "R2", "R4");
      end
      idle(2);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R8 watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule